// File: doc/BRIEF.md
# FIFO Window Length Adapter

This block sits between a host-command decoder and two byte streams inside a device. It takes transfer commands aimed at a reserved FIFO address window and converts them into pops from an outgoing stream (device to host) and pushes into an incoming stream (host to device). A command carries a function number, a direction, a single-register or extended flag, a block/byte mode flag, an incrementing-address opcode bit, a start address and a count field.

The length of every transfer is fixed by the command, never by how much data the streams hold. A host read always yields exactly the commanded number of bytes; once the outgoing stream runs dry the block returns zero bytes for the rest of that transfer. A host write always takes the commanded number of bytes; a byte that arrives while the incoming stream cannot take it is dropped. Commands that fail validation raise a one-cycle error pulse with a reason code and touch neither stream.

Top module: `fifo_window_adapter`

## Requirements
- R1: After reset the block is idle: `cmd_ready` is 1, and `h_rvalid`, `h_wready`, `cmd_err`, `xfer_done`, `tx_pop` and `rx_push` are 0.
- R2: A command whose start address is below 0x090 or above 0x1F7FF is rejected with `cmd_err` high for one cycle and `cmd_err_code` = 3; addresses 0x090 and 0x1F7FF are both accepted.
- R3: A command with a function number other than 1 is rejected with `cmd_err_code` = 1 and causes no pop, no push, and no host data beat.
- R4: An extended command with the incrementing opcode bit clear is rejected with `cmd_err_code` = 2; function errors take priority over opcode errors, which take priority over range errors.
- R5: An extended byte-mode command transfers exactly `cmd_count` bytes, and a count of 0 means 2^CNT_W bytes (512 by default).
- R6: An extended block-mode command transfers `cmd_count` × BLK_BYTES bytes (64 by default); a block count of 0 is rejected with `cmd_err_code` = 4.
- R7: A single-register command transfers exactly one byte whatever its count field and opcode bit hold.
- R8: During a read, each host beat with the outgoing stream holding data returns that stream byte on `h_rdata` and pulses `tx_pop` in the same cycle, in stream order.
- R9: During a read, once a beat finds the outgoing stream empty, that beat and every later beat of the same transfer return 0x00 without popping, even if the stream becomes non-empty again.
- R10: During a write, each host byte is pushed into the incoming stream when `rx_ready` is high and dropped otherwise; dropped bytes still count towards the transfer length.
- R11: `xfer_done` pulses for one cycle right after the last byte of a transfer, at which point `cmd_ready` is 1 again; commands presented while a transfer is running are ignored.
- R12: A cycle with no host beat (`h_rready` low on reads, `h_wvalid` low on writes) advances neither the byte count nor either stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_single | input | 1 | 1 = single-register access (one byte) |
| cmd_write | input | 1 | 1 = host writes, 0 = host reads |
| cmd_func | input | 3 | Function number |
| cmd_block | input | 1 | 1 = block mode, 0 = byte mode (extended only) |
| cmd_incr | input | 1 | Incrementing-address opcode bit (extended only) |
| cmd_addr | input | ADDR_W | Start address |
| cmd_count | input | CNT_W | Byte or block count |
| cmd_err | output | 1 | One-cycle pulse: command rejected |
| cmd_err_code | output | 3 | Reason of last rejection (1 func, 2 opcode, 3 range, 4 zero blocks) |
| xfer_done | output | 1 | One-cycle pulse after the last byte |
| h_wvalid | input | 1 | Host write byte present |
| h_wdata | input | DATA_W | Host write byte |
| h_wready | output | 1 | Write transfer running, byte is taken |
| h_rready | input | 1 | Host takes a read byte this cycle |
| h_rvalid | output | 1 | Read transfer running |
| h_rdata | output | DATA_W | Read byte (stream data or zero pad) |
| tx_valid | input | 1 | Outgoing stream not empty |
| tx_data | input | DATA_W | Outgoing stream head byte |
| tx_pop | output | 1 | Pop outgoing stream head |
| rx_ready | input | 1 | Incoming stream can take a byte |
| rx_push | output | 1 | Push byte into incoming stream |
| rx_data | output | DATA_W | Byte pushed into incoming stream |

## Verification
The assertions assume the stream sides behave as plain FIFO heads: `tx_data` is meaningful only while `tx_valid` is high and `rx_ready` may change freely between cycles, and they assume the host drives `h_wvalid` and `h_rready` only as single-cycle beats with no further handshake. They also take for granted that the command fields are stable whenever `cmd_valid` is high. The stimulus keeps within this by changing every input at the falling edge, holding command fields for the whole accepting cycle, and modelling the outgoing stream in the bench so that its head only advances after a sampled pop.

// File: rtl/fwa_pkg.sv
package fwa_pkg;

  typedef enum logic [2:0] {
    ERR_NONE   = 3'd0,
    ERR_FUNC   = 3'd1,
    ERR_OPCODE = 3'd2,
    ERR_RANGE  = 3'd3,
    ERR_ZBLK   = 3'd4
  } err_e;

endpackage

// File: rtl/fwa_decode.sv
module fwa_decode #(
  parameter int ADDR_W    = 17,
  parameter int CNT_W     = 9,
  parameter int BLK_BYTES = 64,
  parameter int LEN_W     = 16,
  parameter int FUNC_ID   = 1,
  parameter logic [ADDR_W-1:0] WIN_LO = 'h00090,
  parameter logic [ADDR_W-1:0] WIN_HI = 'h1F7FF
) (
  input  logic              cmd_single,
  input  logic [2:0]        cmd_func,
  input  logic              cmd_block,
  input  logic              cmd_incr,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [CNT_W-1:0]  cmd_count,
  output logic              ok,
  output fwa_pkg::err_e     err_code,
  output logic [LEN_W-1:0]  total_len
);

  function automatic logic in_window(input logic [ADDR_W-1:0] a);
    return (a >= WIN_LO) && (a <= WIN_HI);
  endfunction

  function automatic logic [LEN_W-1:0] byte_total(input logic single,
                                                  input logic blk,
                                                  input logic [CNT_W-1:0] cnt);
    logic [LEN_W-1:0] r;
    if (single)            r = LEN_W'(1);
    else if (blk)          r = LEN_W'(cnt) * LEN_W'(BLK_BYTES);
    else if (cnt == '0)    r = LEN_W'(1) << CNT_W;
    else                   r = LEN_W'(cnt);
    return r;
  endfunction

  always_comb begin
    err_code = fwa_pkg::ERR_NONE;
    if (cmd_func != 3'(FUNC_ID))                      err_code = fwa_pkg::ERR_FUNC;
    else if (!cmd_single && !cmd_incr)                err_code = fwa_pkg::ERR_OPCODE;
    else if (!in_window(cmd_addr))                    err_code = fwa_pkg::ERR_RANGE;
    else if (!cmd_single && cmd_block && cmd_count == '0) err_code = fwa_pkg::ERR_ZBLK;
  end

  assign ok        = (err_code == fwa_pkg::ERR_NONE);
  assign total_len = byte_total(cmd_single, cmd_block, cmd_count);

endmodule

// File: rtl/fwa_len_counter.sv
module fwa_len_counter #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len_in,
  input  logic             beat,
  output logic [LEN_W-1:0] remaining,
  output logic             active,
  output logic             last
);

  always_ff @(posedge clk) begin
    if (!rst_n)        remaining <= '0;
    else if (load)     remaining <= len_in;
    else if (beat)     remaining <= remaining - LEN_W'(1);
  end

  assign active = (remaining != '0);
  assign last   = (remaining == LEN_W'(1));

endmodule

// File: rtl/fwa_read_path.sv
module fwa_read_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              last,
  input  logic              h_rready,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              h_rvalid,
  output logic [DATA_W-1:0] h_rdata,
  output logic              tx_pop,
  output logic              beat,
  output logic              padding
);

  logic pad_now;

  assign pad_now  = padding || !tx_valid;
  assign beat     = en && h_rready;
  assign h_rvalid = en;
  assign h_rdata  = (en && !pad_now) ? tx_data : '0;
  assign tx_pop   = beat && !pad_now;

  always_ff @(posedge clk) begin
    if (!rst_n || !en)          padding <= 1'b0;
    else if (beat && last)      padding <= 1'b0;
    else if (beat && pad_now)   padding <= 1'b1;
  end

endmodule

// File: rtl/fwa_write_path.sv
module fwa_write_path #(
  parameter int DATA_W = 8
) (
  input  logic              en,
  input  logic              h_wvalid,
  input  logic [DATA_W-1:0] h_wdata,
  input  logic              rx_ready,
  output logic              h_wready,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_data,
  output logic              beat,
  output logic              drop
);

  assign h_wready = en;
  assign beat     = en && h_wvalid;
  assign rx_push  = beat && rx_ready;
  assign drop     = beat && !rx_ready;
  assign rx_data  = h_wdata;

endmodule

// File: rtl/fifo_window_adapter.sv
module fifo_window_adapter #(
  parameter int ADDR_W    = 17,
  parameter int CNT_W     = 9,
  parameter int DATA_W    = 8,
  parameter int BLK_BYTES = 64,
  parameter int FUNC_ID   = 1,
  parameter logic [ADDR_W-1:0] WIN_LO = 'h00090,
  parameter logic [ADDR_W-1:0] WIN_HI = 'h1F7FF,
  localparam int LEN_W = CNT_W + $clog2(BLK_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_single,
  input  logic              cmd_write,
  input  logic [2:0]        cmd_func,
  input  logic              cmd_block,
  input  logic              cmd_incr,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [CNT_W-1:0]  cmd_count,
  output logic              cmd_err,
  output logic [2:0]        cmd_err_code,
  output logic              xfer_done,
  input  logic              h_wvalid,
  input  logic [DATA_W-1:0] h_wdata,
  output logic              h_wready,
  input  logic              h_rready,
  output logic              h_rvalid,
  output logic [DATA_W-1:0] h_rdata,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_pop,
  input  logic              rx_ready,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_data
);

  // named internal events, also observed by the bound checker
  logic              dec_ok;
  fwa_pkg::err_e     dec_err;
  logic [LEN_W-1:0]  dec_len;
  logic              accept;
  logic              reject;
  logic              active;
  logic              last;
  logic [LEN_W-1:0]  remaining;
  logic              dir_wr;
  logic              rd_beat;
  logic              wr_beat;
  logic              beat;
  logic              padding;
  logic              drop;
  logic              err_q;
  fwa_pkg::err_e     err_code_q;
  logic              done_q;

  fwa_decode #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BLK_BYTES(BLK_BYTES), .LEN_W(LEN_W),
    .FUNC_ID(FUNC_ID), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
  ) u_decode (
    .cmd_single (cmd_single),
    .cmd_func   (cmd_func),
    .cmd_block  (cmd_block),
    .cmd_incr   (cmd_incr),
    .cmd_addr   (cmd_addr),
    .cmd_count  (cmd_count),
    .ok         (dec_ok),
    .err_code   (dec_err),
    .total_len  (dec_len)
  );

  assign cmd_ready = !active;
  assign accept    = cmd_valid && cmd_ready && dec_ok;
  assign reject    = cmd_valid && cmd_ready && !dec_ok;
  assign beat      = rd_beat || wr_beat;

  fwa_len_counter #(.LEN_W(LEN_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .len_in    (dec_len),
    .beat      (beat),
    .remaining (remaining),
    .active    (active),
    .last      (last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      dir_wr <= 1'b0;
    else if (accept) dir_wr <= cmd_write;
  end

  fwa_read_path #(.DATA_W(DATA_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (active && !dir_wr),
    .last     (last),
    .h_rready (h_rready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .h_rvalid (h_rvalid),
    .h_rdata  (h_rdata),
    .tx_pop   (tx_pop),
    .beat     (rd_beat),
    .padding  (padding)
  );

  fwa_write_path #(.DATA_W(DATA_W)) u_wr (
    .en       (active && dir_wr),
    .h_wvalid (h_wvalid),
    .h_wdata  (h_wdata),
    .rx_ready (rx_ready),
    .h_wready (h_wready),
    .rx_push  (rx_push),
    .rx_data  (rx_data),
    .beat     (wr_beat),
    .drop     (drop)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q      <= 1'b0;
      err_code_q <= fwa_pkg::ERR_NONE;
      done_q     <= 1'b0;
    end else begin
      err_q  <= reject;
      done_q <= beat && last;
      if (reject) err_code_q <= dec_err;
    end
  end

  assign cmd_err      = err_q;
  assign cmd_err_code = err_code_q;
  assign xfer_done    = done_q;

endmodule

// File: rtl/fifo_window_adapter_chk.sv
module fifo_window_adapter_chk #(
  parameter int LEN_W  = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              cmd_err,
  input logic              xfer_done,
  input logic              h_wvalid,
  input logic              h_wready,
  input logic              h_rready,
  input logic              h_rvalid,
  input logic [DATA_W-1:0] h_rdata,
  input logic              tx_valid,
  input logic              tx_pop,
  input logic              rx_ready,
  input logic              rx_push,
  input logic              beat,
  input logic              last,
  input logic [LEN_W-1:0]  remaining,
  input logic              padding,
  input logic              drop
);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!h_rvalid && !h_wready && !tx_pop && !rx_push));

  p_err_stays_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> cmd_ready);

  p_pop_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> (tx_valid && h_rready && h_rvalid));

  p_pad_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rvalid && h_rready && !tx_pop) |-> (h_rdata == '0));

  p_pad_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (padding && !(beat && last)) |=> padding);

  p_push_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> (rx_ready && h_wvalid && h_wready));

  p_drop_no_push_r10: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> !rx_push);

  p_hold_count_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && !beat) |=> $stable(remaining));

  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !last) |=> (remaining == $past(remaining) - LEN_W'(1)));

  p_done_after_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (cmd_ready && $past(beat && last)));

endmodule

bind fifo_window_adapter fifo_window_adapter_chk #(.LEN_W(LEN_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .cmd_err   (cmd_err),
  .xfer_done (xfer_done),
  .h_wvalid  (h_wvalid),
  .h_wready  (h_wready),
  .h_rready  (h_rready),
  .h_rvalid  (h_rvalid),
  .h_rdata   (h_rdata),
  .tx_valid  (tx_valid),
  .tx_pop    (tx_pop),
  .rx_ready  (rx_ready),
  .rx_push   (rx_push),
  .beat      (beat),
  .last      (last),
  .remaining (remaining),
  .padding   (padding),
  .drop      (drop)
);

// File: tb/fifo_window_adapter_bench.sv
`timescale 1ns/1ps
module fifo_window_adapter_bench;

  localparam int ADDR_W = 17;
  localparam int CNT_W  = 9;
  localparam int DATA_W = 8;
  localparam int BLK    = 64;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cmd_valid, cmd_ready, cmd_single, cmd_write, cmd_block, cmd_incr;
  logic [2:0]        cmd_func;
  logic [ADDR_W-1:0] cmd_addr;
  logic [CNT_W-1:0]  cmd_count;
  logic              cmd_err, xfer_done;
  logic [2:0]        cmd_err_code;
  logic              h_wvalid, h_wready, h_rready, h_rvalid;
  logic [DATA_W-1:0] h_wdata, h_rdata;
  logic              tx_valid, tx_pop, rx_ready, rx_push;
  logic [DATA_W-1:0] tx_data, rx_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  fifo_window_adapter u_fifo_window_adapter (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_single(cmd_single),
    .cmd_write(cmd_write), .cmd_func(cmd_func), .cmd_block(cmd_block),
    .cmd_incr(cmd_incr), .cmd_addr(cmd_addr), .cmd_count(cmd_count),
    .cmd_err(cmd_err), .cmd_err_code(cmd_err_code), .xfer_done(xfer_done),
    .h_wvalid(h_wvalid), .h_wdata(h_wdata), .h_wready(h_wready),
    .h_rready(h_rready), .h_rvalid(h_rvalid), .h_rdata(h_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop),
    .rx_ready(rx_ready), .rx_push(rx_push), .rx_data(rx_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_cmd(input bit single, input bit wr, input logic [2:0] func,
                          input bit blk, input bit incr, input logic [ADDR_W-1:0] addr,
                          input logic [CNT_W-1:0] cnt);
    cmd_single = single; cmd_write = wr; cmd_func = func; cmd_block = blk;
    cmd_incr = incr; cmd_addr = addr; cmd_count = cnt; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic expect_reject(input logic [2:0] code, input string req);
    chk({req, " err pulse"}, 32'(cmd_err), 1);
    chk({req, " err code"}, 32'(cmd_err_code), 32'(code));
    chk({req, " stays idle"}, 32'(cmd_ready), 1);
  endtask

  // host read of n bytes; bench models the outgoing stream
  task automatic do_read(input int n, input int avail, input int hole, input bit stall,
                         input bit inject, input int exp_pops, input string req);
    int idx = 0;
    bit pad = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (stall && (i % 2 == 1)) begin
        h_rready = 1'b0; tx_valid = (idx < avail); tx_data = 8'hA0 + 8'(idx);
        #1;
        chk({req, " R12 no pop on stall"}, 32'(tx_pop), 0);
        @(posedge clk); @(negedge clk);
      end
      h_rready = 1'b1;
      tx_valid = (idx < avail) && (i != hole);
      tx_data  = 8'hA0 + 8'(idx);
      if (inject && i == 1) begin cmd_valid = 1'b1; cmd_func = 3'd2; end
      if (inject && i == 2) begin
        chk("R11 busy command ignored", 32'(cmd_err), 0);
        cmd_valid = 1'b0; cmd_func = 3'd1;
      end
      #1;
      chk({req, " rvalid"}, 32'(h_rvalid), 1);
      if (!pad && tx_valid) begin
        chk({req, " R8 data"}, 32'(h_rdata), 32'(8'hA0 + 8'(idx)));
        chk({req, " R8 pop"}, 32'(tx_pop), 1);
        @(posedge clk);
        idx++;
      end else begin
        pad = 1'b1;
        chk({req, " R9 zero pad"}, 32'(h_rdata), 0);
        chk({req, " R9 no pop"}, 32'(tx_pop), 0);
        @(posedge clk);
      end
      @(negedge clk);
    end
    h_rready = 1'b0; tx_valid = 1'b0;
    #1;
    chk({req, " R11 done"}, 32'(xfer_done), 1);
    chk({req, " R11 ready"}, 32'(cmd_ready), 1);
    chk({req, " pops"}, 32'(idx), 32'(exp_pops));
    @(negedge clk);
    chk({req, " R11 done one cycle"}, 32'(xfer_done), 0);
  endtask

  // host write of n bytes; mode 0 all ready, 1 some not ready, 2 with stalls
  task automatic do_write(input int n, input int mode, input string req);
    int pushes = 0;
    int exp_pushes = 0;
    for (int i = 0; i < n; i++) begin
      bit rdy;
      if (mode == 2 && (i % 2 == 0)) begin
        h_wvalid = 1'b0; rx_ready = 1'b1;
        #1;
        chk({req, " R12 no push on stall"}, 32'(rx_push), 0);
        chk({req, " R12 still busy"}, 32'(cmd_ready), 0);
        @(posedge clk); @(negedge clk);
      end
      rdy = (mode == 1) ? (i % 3 != 1) : 1'b1;
      h_wvalid = 1'b1; h_wdata = 8'h30 + 8'(i); rx_ready = rdy;
      exp_pushes += int'(rdy);
      #1;
      chk({req, " R10 push"}, 32'(rx_push), 32'(rdy));
      if (rdy) chk({req, " R10 data"}, 32'(rx_data), 32'(8'h30 + 8'(i)));
      pushes += int'(rx_push);
      @(posedge clk); @(negedge clk);
    end
    h_wvalid = 1'b0; rx_ready = 1'b0;
    #1;
    chk({req, " R11 done"}, 32'(xfer_done), 1);
    chk({req, " R11 ready"}, 32'(cmd_ready), 1);
    chk({req, " push count"}, 32'(pushes), 32'(exp_pushes));
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 ready", 32'(cmd_ready), 1);
    chk("R1 rvalid", 32'(h_rvalid), 0);
    chk("R1 wready", 32'(h_wready), 0);
    chk("R1 err", 32'(cmd_err), 0);
    chk("R1 done", 32'(xfer_done), 0);
    chk("R1 pop", 32'(tx_pop), 0);
    chk("R1 push", 32'(rx_push), 0);
  endtask

  task automatic t_window;
    send_cmd(1, 0, 3'd1, 0, 1, 17'h0008F, 9'd1);
    expect_reject(3'd3, "R2 below window");
    send_cmd(0, 1, 3'd1, 0, 1, 17'h1F800, 9'd4);
    expect_reject(3'd3, "R2 above window");
    send_cmd(1, 0, 3'd1, 0, 1, 17'h00090, 9'd1);
    chk("R2 low edge accepted", 32'(cmd_ready), 0);
    do_read(1, 4, -1, 0, 0, 1, "R2 low edge");
    send_cmd(0, 1, 3'd1, 0, 1, 17'h1F7FF, 9'd3);
    chk("R2 high edge accepted", 32'(cmd_err), 0);
    do_write(3, 0, "R2 high edge");
  endtask

  task automatic t_func;
    send_cmd(0, 0, 3'd2, 0, 0, 17'h00100, 9'd4);
    expect_reject(3'd1, "R3 func over opcode");
    h_rready = 1'b1; tx_valid = 1'b1; tx_data = 8'h55;
    #1;
    chk("R3 no pop", 32'(tx_pop), 0);
    chk("R3 no read beat", 32'(h_rvalid), 0);
    @(negedge clk);
    h_rready = 1'b0; tx_valid = 1'b0;
    send_cmd(1, 1, 3'd0, 0, 1, 17'h00100, 9'd1);
    expect_reject(3'd1, "R3 func zero");
    h_wvalid = 1'b1; rx_ready = 1'b1;
    #1;
    chk("R3 no push", 32'(rx_push), 0);
    chk("R3 no write beat", 32'(h_wready), 0);
    @(negedge clk);
    h_wvalid = 1'b0; rx_ready = 1'b0;
  endtask

  task automatic t_opcode;
    send_cmd(0, 1, 3'd1, 0, 0, 17'h00000, 9'd4);
    expect_reject(3'd2, "R4 opcode over range");
    send_cmd(1, 1, 3'd1, 0, 0, 17'h00200, 9'd5);
    chk("R7 single accepted", 32'(cmd_ready), 0);
    do_write(1, 0, "R7 single write one byte");
    send_cmd(1, 0, 3'd1, 1, 0, 17'h00200, 9'd0);
    do_read(1, 3, -1, 0, 0, 1, "R7 single read one byte");
  endtask

  task automatic t_read_order;
    send_cmd(0, 0, 3'd1, 0, 1, 17'h00400, 9'd5);
    do_read(5, 8, -1, 0, 0, 5, "R5 R8 byte read");
  endtask

  task automatic t_pad;
    send_cmd(0, 0, 3'd1, 0, 1, 17'h00400, 9'd6);
    do_read(6, 3, -1, 0, 0, 3, "R9 short stream");
    send_cmd(0, 0, 3'd1, 0, 1, 17'h00400, 9'd6);
    do_read(6, 20, 2, 0, 0, 2, "R9 sticky pad");
  endtask

  task automatic t_write_drop;
    send_cmd(0, 1, 3'd1, 0, 1, 17'h00800, 9'd7);
    do_write(7, 1, "R10 drops");
  endtask

  task automatic t_block;
    send_cmd(0, 1, 3'd1, 1, 1, 17'h01000, 9'd2);
    do_write(2 * BLK, 0, "R6 two blocks");
    send_cmd(0, 0, 3'd1, 1, 1, 17'h01000, 9'd0);
    expect_reject(3'd4, "R6 zero blocks");
  endtask

  task automatic t_zero_count;
    send_cmd(0, 0, 3'd1, 0, 1, 17'h02000, 9'd0);
    do_read(1 << CNT_W, 0, -1, 0, 0, 0, "R5 count zero");
  endtask

  task automatic t_stall;
    send_cmd(0, 0, 3'd1, 0, 1, 17'h02000, 9'd4);
    do_read(4, 10, -1, 1, 0, 4, "R12 read stall");
    send_cmd(0, 1, 3'd1, 0, 1, 17'h02000, 9'd4);
    do_write(4, 2, "R12 write stall");
  endtask

  task automatic t_busy;
    send_cmd(0, 0, 3'd1, 0, 1, 17'h03000, 9'd4);
    do_read(4, 10, -1, 0, 1, 4, "R11 busy");
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_single = 1'b0; cmd_write = 1'b0;
    cmd_func = 3'd1; cmd_block = 1'b0; cmd_incr = 1'b1; cmd_addr = '0; cmd_count = '0;
    h_wvalid = 1'b0; h_wdata = '0; h_rready = 1'b0; tx_valid = 1'b0; tx_data = '0;
    rx_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_window;
    t_func;
    t_opcode;
    t_read_order;
    t_pad;
    t_write_drop;
    t_block;
    t_zero_count;
    t_stall;
    t_busy;
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule